// File: doc/BRIEF.md
# Handshaking Single-Channel Mailbox

This block passes one command word and one data word in each direction between two agents, side A and side B. Each agent has its own register port. A second register set carries traffic the other way. Posting a message raises a pending flag that the receiving agent can see. When the receiver writes one to that flag to clear it, an acknowledge flag is raised in the status register that the sender reads. Each register set carries its own trigger-select bit. This bit decides whether the message is posted by the command-word write or by the data-word write.

Each side has its own interrupt. An interrupt is the OR of the enabled status bits in the register set that side receives on. A static role-swap input exchanges which register set each side receives on. Both ports run on one clock. Each can read and write every register, and read data is combinational from the current address.

Top module: `hs_mailbox`

## Requirements
- R1: After reset, every register reads zero: enables, trigger bits, status, command and data. Both interrupts are low.
- R2: The enable register holds three control bits: bit 0 enables the pending interrupt, bit 1 enables the acknowledge interrupt, and bit 8 is the trigger select. Bit n of the register takes the written value only when bit n+16 of the same write is one; otherwise it keeps its value. All other bits read zero.
- R3: With the trigger bit at 0, a write to the command register posts the message, and status bit 0 (pending) reads one from the next cycle. A write to the data register does not post.
- R4: With the trigger bit at 1, a write to the command register stores the word but does not post. A write to the data register posts the message.
- R5: Writing a one to a status bit (bit 0 pending, bit 1 acknowledge) clears that bit. Writing a zero leaves the bit unchanged.
- R6: Clearing status bit 0 of one set while it is one sets status bit 1 of the other set. Clearing it while it is already zero sets nothing.
- R7: While status bit 0 of a set is one, writes to that set's command and data registers are ignored. Their contents are kept and no new post occurs.
- R8: With the swap input low, irqB is the OR of (status AND enable bits 1:0) for set 0, and irqA is the same function for set 1.
- R9: With the swap input high, the mapping is exchanged: irqA follows set 0 and irqB follows set 1.
- R10: Address bit 4 selects the set (0: A-to-B, 1: B-to-A). Bits 3:2 select the register: 0 enable, 1 status, 2 command, 3 data. Either port can read and write every register.
- R11: If both ports write the same register in the same cycle, port A's write takes effect. Status clears from both ports are combined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Active-low synchronous reset |
| swapRoles | input | 1 | Exchanges which set each side receives on |
| aWrEn | input | 1 | Side A write strobe |
| aAddr | input | 5 | Side A byte address |
| aWdata | input | 32 | Side A write data |
| aRdata | output | 32 | Side A read data for aAddr |
| bWrEn | input | 1 | Side B write strobe |
| bAddr | input | 5 | Side B byte address |
| bWdata | input | 32 | Side B write data |
| bRdata | output | 32 | Side B read data for bAddr |
| irqA | output | 1 | Side A interrupt |
| irqB | output | 1 | Side B interrupt |

## Verification
The assertions check four rules on every cycle. Pending can rise or fall only after a port write. Every fall of a pending flag is matched by the acknowledge flag of the other set. An interrupt never stands without some status bit behind it. The bench's scenarios are needed for the rest: the masked enable write, the trigger-select ordering, the write lock while a message is pending, the role-swap mapping and same-cycle collisions between the ports. A behavioural reference model checks all of these against both read ports and both interrupts.

// File: rtl/hs_mailbox_pkg.sv
package hs_mailbox_pkg;
  localparam int MB_DW    = 32;
  localparam int NSETS    = 2;
  localparam int TRIG_BIT = 8;
  localparam int MASK_OFS = MB_DW / 2;
  localparam int REG_LO   = 2;
  localparam int REG_HI   = 3;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_STAT = 2'd1,
    REG_CMD  = 2'd2,
    REG_DATA = 2'd3
  } regSel_e;

  // Strobes from control to datapath for one register set.
  // enSet/enBit order: {trigger, ackEnable, pendEnable}
  typedef struct packed {
    logic [2:0]       enSet;
    logic [2:0]       enBit;
    logic [1:0]       stClr;
    logic             cmdWe;
    logic             datWe;
    logic [MB_DW-1:0] cmdVal;
    logic [MB_DW-1:0] datVal;
    logic             post;
    logic             ackIn;
  } setStrb_t;
endpackage

// File: rtl/hs_mailbox_ctrl.sv
module hs_mailbox_ctrl
  import hs_mailbox_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                       aWrEn,
  input  logic [ADDR_W-1:0]          aAddr,
  input  logic [MB_DW-1:0]           aWdata,
  input  logic                       bWrEn,
  input  logic [ADDR_W-1:0]          bAddr,
  input  logic [MB_DW-1:0]           bWdata,
  input  logic [NSETS-1:0]           pend,
  input  logic [NSETS-1:0]           trig,
  output setStrb_t [NSETS-1:0]       strb
);
  localparam int SET_BIT = ADDR_W - 1;

  logic [NSETS-1:0][1:0] clrV;

  for (genvar k = 0; k < NSETS; k++) begin : g_set
    logic     aHit, bHit;
    regSel_e  aReg, bReg;
    logic     aEn, bEn, aSt, bSt, aCmd, bCmd, aDat, bDat;
    logic [MB_DW-1:0] enVal;
    setStrb_t s;

    assign aHit = aWrEn && (aAddr[SET_BIT] == 1'(k));
    assign bHit = bWrEn && (bAddr[SET_BIT] == 1'(k));
    assign aReg = regSel_e'(aAddr[REG_HI:REG_LO]);
    assign bReg = regSel_e'(bAddr[REG_HI:REG_LO]);

    assign aEn  = aHit && (aReg == REG_EN);
    assign bEn  = bHit && (bReg == REG_EN);
    assign aSt  = aHit && (aReg == REG_STAT);
    assign bSt  = bHit && (bReg == REG_STAT);
    assign aCmd = aHit && (aReg == REG_CMD);
    assign bCmd = bHit && (bReg == REG_CMD);
    assign aDat = aHit && (aReg == REG_DATA);
    assign bDat = bHit && (bReg == REG_DATA);

    // port A wins a same-register collision
    assign enVal   = aEn ? aWdata : bWdata;
    assign clrV[k] = (aSt ? aWdata[1:0] : 2'b00) | (bSt ? bWdata[1:0] : 2'b00);

    always_comb begin
      s        = '0;
      s.enSet  = {enVal[TRIG_BIT+MASK_OFS], enVal[1+MASK_OFS], enVal[MASK_OFS]}
                 & {3{aEn | bEn}};
      s.enBit  = {enVal[TRIG_BIT], enVal[1], enVal[0]};
      s.stClr  = clrV[k];
      s.cmdWe  = (aCmd | bCmd) && !pend[k];
      s.datWe  = (aDat | bDat) && !pend[k];
      s.cmdVal = aCmd ? aWdata : bWdata;
      s.datVal = aDat ? aWdata : bWdata;
      s.post   = trig[k] ? s.datWe : s.cmdWe;
      s.ackIn  = clrV[NSETS-1-k][0] && pend[NSETS-1-k];
    end

    assign strb[k] = s;
  end
endmodule

// File: rtl/hs_mailbox_dpath.sv
module hs_mailbox_dpath
  import hs_mailbox_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   swapRoles,
  input  setStrb_t [NSETS-1:0]   strb,
  input  logic [ADDR_W-1:0]      aAddr,
  input  logic [ADDR_W-1:0]      bAddr,
  output logic [MB_DW-1:0]       aRdata,
  output logic [MB_DW-1:0]       bRdata,
  output logic                   irqA,
  output logic                   irqB,
  output logic [NSETS-1:0][1:0]  stat,
  output logic [NSETS-1:0]       trig
);
  localparam int SET_BIT = ADDR_W - 1;

  logic [NSETS-1:0][3:0][MB_DW-1:0] words;
  logic [NSETS-1:0]                 rxIrq;

  for (genvar k = 0; k < NSETS; k++) begin : g_set
    logic [1:0]       enQ;
    logic             trigQ;
    logic [1:0]       statQ;
    logic [MB_DW-1:0] cmdQ, datQ;
    logic [MB_DW-1:0] enWord, stWord;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ   <= '0;
        trigQ <= 1'b0;
        statQ <= '0;
        cmdQ  <= '0;
        datQ  <= '0;
      end else begin
        if (strb[k].enSet[0]) enQ[0] <= strb[k].enBit[0];
        if (strb[k].enSet[1]) enQ[1] <= strb[k].enBit[1];
        if (strb[k].enSet[2]) trigQ  <= strb[k].enBit[2];
        if (strb[k].cmdWe)    cmdQ   <= strb[k].cmdVal;
        if (strb[k].datWe)    datQ   <= strb[k].datVal;
        statQ[0] <= strb[k].post  | (statQ[0] & ~strb[k].stClr[0]);
        statQ[1] <= strb[k].ackIn | (statQ[1] & ~strb[k].stClr[1]);
      end
    end

    always_comb begin
      enWord           = '0;
      enWord[1:0]      = enQ;
      enWord[TRIG_BIT] = trigQ;
      stWord           = '0;
      stWord[1:0]      = statQ;
    end

    assign words[k][REG_EN]   = enWord;
    assign words[k][REG_STAT] = stWord;
    assign words[k][REG_CMD]  = cmdQ;
    assign words[k][REG_DATA] = datQ;
    assign rxIrq[k] = |(statQ & enQ);
    assign stat[k]  = statQ;
    assign trig[k]  = trigQ;
  end

  assign aRdata = words[aAddr[SET_BIT]][aAddr[REG_HI:REG_LO]];
  assign bRdata = words[bAddr[SET_BIT]][bAddr[REG_HI:REG_LO]];

  // default: A receives on set 1, B on set 0
  assign irqA = swapRoles ? rxIrq[0] : rxIrq[1];
  assign irqB = swapRoles ? rxIrq[1] : rxIrq[0];

  logic unusedAddr;
  assign unusedAddr = ^{aAddr[REG_LO-1:0], bAddr[REG_LO-1:0]};
endmodule

// File: rtl/hs_mailbox.sv
module hs_mailbox
  import hs_mailbox_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swapRoles,
  input  logic              aWrEn,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [MB_DW-1:0]  aWdata,
  output logic [MB_DW-1:0]  aRdata,
  input  logic              bWrEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [MB_DW-1:0]  bWdata,
  output logic [MB_DW-1:0]  bRdata,
  output logic              irqA,
  output logic              irqB
);
  setStrb_t [NSETS-1:0]  strbW;
  logic [NSETS-1:0][1:0] statW;
  logic [NSETS-1:0]      trigW;
  logic [NSETS-1:0]      pendW;

  for (genvar k = 0; k < NSETS; k++) begin : g_pend
    assign pendW[k] = statW[k][0];
  end

  hs_mailbox_ctrl #(.ADDR_W(ADDR_W)) ctrlI (
    .aWrEn(aWrEn), .aAddr(aAddr), .aWdata(aWdata),
    .bWrEn(bWrEn), .bAddr(bAddr), .bWdata(bWdata),
    .pend(pendW), .trig(trigW), .strb(strbW)
  );

  hs_mailbox_dpath #(.ADDR_W(ADDR_W)) dpathI (
    .clk(clk), .rstN(rstN), .swapRoles(swapRoles), .strb(strbW),
    .aAddr(aAddr), .bAddr(bAddr), .aRdata(aRdata), .bRdata(bRdata),
    .irqA(irqA), .irqB(irqB), .stat(statW), .trig(trigW)
  );
endmodule

// File: rtl/hs_mailbox_chk.sv
module hs_mailbox_chk
  import hs_mailbox_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  aWrEn,
  input logic                  bWrEn,
  input logic                  irqA,
  input logic                  irqB,
  input logic [NSETS-1:0][1:0] statV
);
  // R3
  post_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statV[0][0]) |-> $past(aWrEn || bWrEn));

  // R5
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statV[1][0]) |-> $past(aWrEn || bWrEn));

  // R6
  ack_to_set1_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statV[0][0]) |-> statV[1][1]);

  // R6
  ack_to_set0_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statV[1][0]) |-> statV[0][1]);

  // R8
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqA || irqB) |-> (|statV));
endmodule

bind hs_mailbox hs_mailbox_chk chkI (
  .clk(clk), .rstN(rstN), .aWrEn(aWrEn), .bWrEn(bWrEn),
  .irqA(irqA), .irqB(irqB), .statV(statW)
);

// File: tb/hs_mailbox_test.sv
`timescale 1ns/100ps
module hs_mailbox_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swapRoles = 1'b0;
  logic        aWrEn = 1'b0, bWrEn = 1'b0;
  logic [4:0]  aAddr = '0, bAddr = '0;
  logic [31:0] aWdata = '0, bWdata = '0;
  logic [31:0] aRdata, bRdata;
  logic        irqA, irqB;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hs_mailbox uut (
    .clk(clk), .rstN(rstN), .swapRoles(swapRoles),
    .aWrEn(aWrEn), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bWrEn(bWrEn), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata),
    .irqA(irqA), .irqB(irqB)
  );

  // ---------------- behavioural reference model ----------------
  int          mEn[2], mTrig[2], mStat[2];
  logic [31:0] mCmd[2], mDat[2];

  always @(posedge clk) begin
    int oStat[2], oTrig[2], clr[2];
    bit post[2];
    if (!rstN) begin
      foreach (mEn[k]) begin
        mEn[k] = 0; mTrig[k] = 0; mStat[k] = 0; mCmd[k] = 0; mDat[k] = 0;
      end
    end else begin
      oStat = mStat; oTrig = mTrig;
      for (int k = 0; k < 2; k++) begin
        bit aH, bH, cmdOk, datOk;
        logic [31:0] w;
        aH = aWrEn && (aAddr[4] == k[0]);
        bH = bWrEn && (bAddr[4] == k[0]);
        w = 'x;
        if (aH && aAddr[3:2] == 0) w = aWdata;
        else if (bH && bAddr[3:2] == 0) w = bWdata;
        if (!$isunknown(w)) begin
          if (w[16]) mEn[k] = (mEn[k] & 2) | int'(w[0]);
          if (w[17]) mEn[k] = (mEn[k] & 1) | (int'(w[1]) << 1);
          if (w[24]) mTrig[k] = int'(w[8]);
        end
        clr[k] = 0;
        if (aH && aAddr[3:2] == 1) clr[k] |= int'(aWdata[1:0]);
        if (bH && bAddr[3:2] == 1) clr[k] |= int'(bWdata[1:0]);
        cmdOk = ((aH && aAddr[3:2] == 2) || (bH && bAddr[3:2] == 2)) && oStat[k][0] == 0;
        datOk = ((aH && aAddr[3:2] == 3) || (bH && bAddr[3:2] == 3)) && oStat[k][0] == 0;
        if (cmdOk) mCmd[k] = (aH && aAddr[3:2] == 2) ? aWdata : bWdata;
        if (datOk) mDat[k] = (aH && aAddr[3:2] == 3) ? aWdata : bWdata;
        post[k] = oTrig[k] ? datOk : cmdOk;
      end
      for (int k = 0; k < 2; k++) begin
        int b0, b1;
        b0 = post[k] ? 1 : ((clr[k] & 1) ? 0 : (oStat[k] & 1));
        b1 = ((clr[1-k] & 1) && (oStat[1-k] & 1)) ? 1
             : ((clr[k] & 2) ? 0 : ((oStat[k] >> 1) & 1));
        mStat[k] = b0 | (b1 << 1);
      end
    end
  end

  function automatic logic [31:0] mRead(input logic [4:0] ad);
    int s;
    s = int'(ad[4]);
    case (ad[3:2])
      2'd0: return 32'(mEn[s]) | (32'(mTrig[s]) << 8);
      2'd1: return 32'(mStat[s]);
      2'd2: return mCmd[s];
      default: return mDat[s];
    endcase
  endfunction

  function automatic logic mIrq(input int s);
    return (mStat[s] & mEn[s]) != 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R10 read path, R8/R9 irqs)
  always @(negedge clk) begin
    #0.5;
    if (rstN && !done) begin
      chk("R10 model aRdata", aRdata, mRead(aAddr));
      chk("R10 model bRdata", bRdata, mRead(bAddr));
      chk("R8 model irqA", 32'(irqA), 32'(swapRoles ? mIrq(0) : mIrq(1)));
      chk("R8 model irqB", 32'(irqB), 32'(swapRoles ? mIrq(1) : mIrq(0)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wrA(input logic [4:0] ad, input logic [31:0] d);
    @(negedge clk); aWrEn = 1; aAddr = ad; aWdata = d;
    @(negedge clk); aWrEn = 0;
  endtask

  task automatic wrB(input logic [4:0] ad, input logic [31:0] d);
    @(negedge clk); bWrEn = 1; bAddr = ad; bWdata = d;
    @(negedge clk); bWrEn = 0;
  endtask

  task automatic wrAB(input logic [4:0] ad, input logic [31:0] da,
                      input logic [4:0] bd, input logic [31:0] db);
    @(negedge clk); aWrEn = 1; aAddr = ad; aWdata = da;
    bWrEn = 1; bAddr = bd; bWdata = db;
    @(negedge clk); aWrEn = 0; bWrEn = 0;
  endtask

  task automatic rdA(input logic [4:0] ad, input logic [31:0] exp, input string tag);
    aAddr = ad; #0.5; chk(tag, aRdata, exp);
  endtask

  task automatic rdB(input logic [4:0] ad, input logic [31:0] exp, input string tag);
    bAddr = ad; #0.5; chk(tag, bRdata, exp);
  endtask

  task automatic irqs(input logic ea, input logic eb, input string tag);
    #0.5; chk({tag, " irqA"}, 32'(irqA), 32'(ea)); chk({tag, " irqB"}, 32'(irqB), 32'(eb));
  endtask

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) rdA(5'(i * 4), 32'h0, "R1 reset value");
    irqs(0, 0, "R1");

    // R2 masked enable writes on set 0
    wrB(5'h00, 32'h0000_0103); rdA(5'h00, 32'h0, "R2 no mask bits");
    wrB(5'h00, 32'h0001_0003); rdA(5'h00, 32'h1, "R2 only bit0 masked");
    wrB(5'h00, 32'h0102_0000); rdA(5'h00, 32'h1, "R2 masked zeros");
    wrB(5'h00, 32'h0100_0100); rdA(5'h00, 32'h101, "R2 trigger set");
    wrB(5'h00, 32'h0100_0000); rdA(5'h00, 32'h1, "R2 trigger clear");

    // R3 command-write trigger
    wrA(5'h0C, 32'hDEAD_0001); rdA(5'h04, 32'h0, "R3 data write no post");
    rdB(5'h0C, 32'hDEAD_0001, "R10 data via port B");
    wrA(5'h08, 32'h11); rdB(5'h04, 32'h1, "R3 cmd write posts");
    irqs(0, 1, "R8 pending to B");

    // R7 lock while pending
    wrA(5'h08, 32'h22); rdB(5'h08, 32'h11, "R7 cmd kept");
    wrA(5'h0C, 32'h55); rdB(5'h0C, 32'hDEAD_0001, "R7 data kept");

    // R5 / R6 acknowledge
    wrB(5'h04, 32'h0); rdB(5'h04, 32'h1, "R5 write zero keeps");
    wrB(5'h04, 32'h1); rdB(5'h04, 32'h0, "R5 pending cleared");
    rdA(5'h14, 32'h2, "R6 ack raised in set1");
    irqs(0, 0, "R8 ack disabled");
    wrA(5'h10, 32'h0002_0002); irqs(1, 0, "R8 ack enabled");
    wrA(5'h14, 32'h2); rdA(5'h14, 32'h0, "R5 ack cleared");
    irqs(0, 0, "R5 irq drop");
    wrB(5'h04, 32'h1); rdA(5'h14, 32'h0, "R6 clear of idle no ack");

    // R4 data-write trigger on set 1
    wrB(5'h10, 32'h0100_0100); rdB(5'h10, 32'h102, "R2 set1 trigger");
    wrB(5'h18, 32'h33); rdA(5'h14, 32'h0, "R4 cmd no post");
    rdA(5'h18, 32'h33, "R4 cmd stored");
    wrB(5'h1C, 32'h44); rdA(5'h14, 32'h1, "R4 data posts");
    irqs(0, 0, "R8 pend disabled");
    wrA(5'h10, 32'h0001_0001); irqs(1, 0, "R8 pend to A");

    // R9 swap
    @(negedge clk); swapRoles = 1; irqs(0, 1, "R9 swapped");
    @(negedge clk); swapRoles = 0; irqs(1, 0, "R9 restored");

    wrA(5'h14, 32'h1); rdB(5'h04, 32'h2, "R6 ack into set0");
    irqs(0, 0, "R6 irqs");

    // R11 collisions
    wrAB(5'h08, 32'hAAAA, 5'h08, 32'hBBBB);
    rdB(5'h08, 32'hAAAA, "R11 port A cmd wins");
    rdB(5'h04, 32'h3, "R11 collided post");
    wrAB(5'h04, 32'h1, 5'h04, 32'h2);
    rdA(5'h04, 32'h0, "R11 combined clears");
    rdA(5'h14, 32'h2, "R11 ack from combined");
    wrAB(5'h00, 32'h0002_0002, 5'h00, 32'h0001_0000);
    rdA(5'h00, 32'h3, "R11 port A enable wins");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule